// File: doc/BRIEF.md
# Two-stage multiplexed B-to-A register path

This block carries data in the B-to-A direction of a four-way multiplexed transceiver. Each of four input lanes on the B side has its own first-stage storage cell. A two-bit select steers one of those cells onto an internal node. A second storage cell on the A side takes that node and drives the A output, qualified by an output enable. Both stages are built from the same cell, which can follow its input like an open latch or capture it on the rising edge of a shared device strobe. Depending on how the enables are set, the path acts as a two-deep pipeline or as a chain of pass-through latches.

The whole path runs on the system clock. The device strobe is an ordinary input, and its rising edge is found by comparing it with its value on the previous cycle. A cell in follow mode loads its input on every system clock, so a value reaches the cell one cycle after it is applied. The A-side value is always visible, and a separate drive bit says whether the output is driven. A synchronous reset clears both stages to zero.

Top module: `ba_mux_path`

## Requirements
- R1: While a lane's follow enable (`lane_le[i]`) is 1, that lane's first-stage cell takes its B input on every clock, one cycle after the input is applied.
- R2: When a lane's follow enable is 0 and the shared first-stage capture enable `lane_ce_n` is 0, the lane cell captures its B input on a rising edge of `ba_strobe`. All lanes share that one enable, and the select does not steer it.
- R3: When `lane_ce_n` is 1, or when no rising edge of `ba_strobe` occurs, a lane cell whose follow enable is 0 keeps its stored value.
- R4: The select chooses lane 1 (bits [W-1:0] of `b_lanes`) for `lane_sel`=00, lane 2 for 01, lane 3 for 10 and lane 4 for 11.
- R5: While `out_le` is 1, the output cell takes the selected lane value on every clock.
- R6: When `out_le` is 0 and `out_ce_n` is 0, the output cell captures the selected lane value on a rising edge of `ba_strobe`.
- R7: When `out_le` is 0 and either `out_ce_n` is 1 or no strobe edge occurs, `a_val` holds its previous value.
- R8: When both stages capture on the same strobe edge, the output takes the selected first-stage value from before that edge. The new lane data reaches the output only on the next edge.
- R9: `a_drive` is 1 exactly when `a_oe_n` is 0, with no clock delay. `a_val` is unaffected by `a_oe_n`.
- R10: A synchronous reset clears every lane cell and the output cell to 0.
- R11: A strobe held high causes only one capture. Later changes to the B inputs are not taken until the strobe falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ba_strobe | input | 1 | Device strobe; its rising edge triggers captures |
| lane_ce_n | input | 1 | Shared first-stage capture enable, active low |
| lane_le | input | LANES | Per-lane follow enable |
| lane_sel | input | SEL_W | Lane select for the internal node |
| out_le | input | 1 | Output cell follow enable |
| out_ce_n | input | 1 | Output cell capture enable, active low |
| a_oe_n | input | 1 | A output enable, active low |
| b_lanes | input | LANES*W | B inputs, lane 1 in the low bits |
| a_val | output | W | Output cell value |
| a_drive | output | 1 | 1 when the A output is driven |

## Verification
The assertions treat `ba_strobe` as a level sampled by the system clock. They assume each strobe high and low phase lasts at least one full clock, so that an edge is seen as a single-cycle event. They also assume the B inputs and the selects are steady at the sampling edge. The bench therefore changes all inputs 2 ns after a rising clock edge. It holds each strobe level for at least one whole cycle, and it samples `a_val` only after the cycles needed for data to pass through one or both stages.

// File: rtl/ba_mux_pkg.sv
package ba_mux_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_FOLLOW  = 2'd1,
    ACT_CAPTURE = 2'd2
  } cell_act_e;

  // What a storage cell does this clock, from its enables and the strobe edge.
  function automatic cell_act_e cell_action(input logic le, input logic rise, input logic ce_n);
    if (le)
      return ACT_FOLLOW;
    else if (rise && !ce_n)
      return ACT_CAPTURE;
    else
      return ACT_HOLD;
  endfunction
endpackage

// File: rtl/ba_strobe_edge.sv
module ba_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  output logic rise_o
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe_in;
  end

  assign rise_o = strobe_in & ~strobe_q;

  // R11: a held strobe yields only one capture event
  a_r11_single_rise: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ba_store_cell.sv
module ba_store_cell
  import ba_mux_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic         rise,
  input  logic         ce_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  cell_act_e act;
  assign act = cell_action(le, rise, ce_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (act)
        ACT_FOLLOW, ACT_CAPTURE: q <= d;
        default:                 q <= q;
      endcase
    end
  end

  // R1 for lane cells, R5 for the output cell
  a_r1_follow: assert property (@(posedge clk) disable iff (rst)
    le |=> q == $past(d));
  // R2 for lane cells, R6 for the output cell
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    (!le && rise && !ce_n) |=> q == $past(d));
  // R3 for lane cells, R7 for the output cell
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!le && (!rise || ce_n)) |=> $stable(q));
endmodule

// File: rtl/ba_lane_select.sv
module ba_lane_select #(
  parameter int W     = 4,
  parameter int LANES = 4,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [LANES*W-1:0] lanes,
  input  logic [SEL_W-1:0]   sel,
  output logic [W-1:0]       node
);
  logic [W-1:0] lane_arr [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_unpack
    assign lane_arr[i] = lanes[i*W +: W];
  end

  assign node = lane_arr[sel];
endmodule

// File: rtl/ba_mux_path.sv
module ba_mux_path #(
  parameter int W     = 4,
  parameter int LANES = 4,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ba_strobe,
  input  logic               lane_ce_n,
  input  logic [LANES-1:0]   lane_le,
  input  logic [SEL_W-1:0]   lane_sel,
  input  logic               out_le,
  input  logic               out_ce_n,
  input  logic               a_oe_n,
  input  logic [LANES*W-1:0] b_lanes,
  output logic [W-1:0]       a_val,
  output logic               a_drive
);
  logic               strobe_rise;
  logic [LANES*W-1:0] stage1_q;
  logic [W-1:0]       mux_node;

  ba_strobe_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .strobe_in(ba_strobe),
    .rise_o   (strobe_rise)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    ba_store_cell #(.W(W)) u_cell (
      .clk (clk),
      .rst (rst),
      .le  (lane_le[i]),
      .rise(strobe_rise),
      .ce_n(lane_ce_n),
      .d   (b_lanes[i*W +: W]),
      .q   (stage1_q[i*W +: W])
    );
  end

  ba_lane_select #(.W(W), .LANES(LANES)) u_sel (
    .lanes(stage1_q),
    .sel  (lane_sel),
    .node (mux_node)
  );

  ba_store_cell #(.W(W)) u_out (
    .clk (clk),
    .rst (rst),
    .le  (out_le),
    .rise(strobe_rise),
    .ce_n(out_ce_n),
    .d   (mux_node),
    .q   (a_val)
  );

  assign a_drive = ~a_oe_n;

  // R10: the cycle after reset the output is cleared
  a_r10_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> a_val == '0);
  // R8: a joint capture hands the output the pre-edge node value
  a_r8_pipeline: assert property (@(posedge clk) disable iff (rst)
    (strobe_rise && !out_le && !out_ce_n && !lane_ce_n) |=> a_val == $past(mux_node));
endmodule

// File: tb/ba_mux_path_tb_top.sv
module ba_mux_path_tb_top;
  localparam int W = 4;
  localparam int LANES = 4;

  logic clk = 1'b0;
  logic rst, ba_strobe, lane_ce_n, out_le, out_ce_n, a_oe_n;
  logic [LANES-1:0]   lane_le;
  logic [1:0]         lane_sel;
  logic [LANES*W-1:0] b_lanes;
  logic [W-1:0]       a_val;
  logic               a_drive;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ba_mux_path #(.W(W), .LANES(LANES)) dut_i (
    .clk(clk), .rst(rst), .ba_strobe(ba_strobe), .lane_ce_n(lane_ce_n),
    .lane_le(lane_le), .lane_sel(lane_sel), .out_le(out_le), .out_ce_n(out_ce_n),
    .a_oe_n(a_oe_n), .b_lanes(b_lanes), .a_val(a_val), .a_drive(a_drive)
  );

  function automatic logic [LANES*W-1:0] pack4(input logic [3:0] l1, input logic [3:0] l2,
                                               input logic [3:0] l3, input logic [3:0] l4);
    return {l4, l3, l2, l1};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse_strobe();
    ba_strobe = 1'b1; cyc(1);
    ba_strobe = 1'b0; cyc(1);
  endtask

  task automatic read_lane(input string req, input int s, input logic [3:0] exp);
    lane_sel = 2'(s); cyc(1);
    chk(req, a_val, exp);
  endtask

  task automatic t_reset_state();
    rst = 1'b1; ba_strobe = 1'b0; lane_ce_n = 1'b1; out_le = 1'b0; out_ce_n = 1'b1;
    a_oe_n = 1'b1; lane_le = '0; lane_sel = '0; b_lanes = pack4(4'h7, 4'h7, 4'h7, 4'h7);
    cyc(3);
    chk("R10 reset", a_val, 4'h0);
    rst = 1'b0; cyc(1);
    chk("R10 after reset", a_val, 4'h0);
  endtask

  task automatic t_transparent();
    lane_le = '1; out_le = 1'b1;
    b_lanes = pack4(4'h3, 4'h5, 4'h9, 4'hC);
    cyc(2);
    read_lane("R1 R4 R5 sel00 lane1", 0, 4'h3);
    read_lane("R4 sel01 lane2", 1, 4'h5);
    read_lane("R4 sel10 lane3", 2, 4'h9);
    read_lane("R4 sel11 lane4", 3, 4'hC);
  endtask

  task automatic t_lane_capture();
    lane_le = '0; lane_ce_n = 1'b0;
    b_lanes = pack4(4'hA, 4'h6, 4'h1, 4'hE);
    cyc(3);
    read_lane("R3 no edge lane1 held", 0, 4'h3);
    read_lane("R3 no edge lane4 held", 3, 4'hC);
    pulse_strobe();
    b_lanes = pack4(4'hF, 4'hF, 4'hF, 4'hF);
    cyc(1);
    for (int s = 0; s < 4; s++) begin
      logic [3:0] e;
      e = (s == 0) ? 4'hA : (s == 1) ? 4'h6 : (s == 2) ? 4'h1 : 4'hE;
      read_lane("R2 captured on strobe edge", s, e);
    end
  endtask

  task automatic t_held_strobe();
    b_lanes = pack4(4'h2, 4'h4, 4'h6, 4'h8);
    ba_strobe = 1'b1; cyc(1);
    b_lanes = pack4(4'hB, 4'hB, 4'hB, 4'hB);
    cyc(3);
    ba_strobe = 1'b0; cyc(1);
    read_lane("R11 held strobe lane1", 0, 4'h2);
    read_lane("R11 held strobe lane3", 2, 4'h6);
  endtask

  task automatic t_ce_blocked();
    lane_ce_n = 1'b1;
    b_lanes = pack4(4'h1, 4'h1, 4'h1, 4'h1);
    pulse_strobe();
    read_lane("R3 ce high lane2 held", 1, 4'h4);
    read_lane("R3 ce high lane4 held", 3, 4'h8);
  endtask

  task automatic t_pipeline();
    lane_ce_n = 1'b0; out_le = 1'b0; out_ce_n = 1'b0; lane_sel = 2'd2;
    cyc(2);
    chk("R7 output holds without edge", a_val, 4'h8);
    b_lanes = pack4(4'h1, 4'h3, 4'h5, 4'h7);
    pulse_strobe();
    chk("R8 output takes pre-edge lane3", a_val, 4'h6);
    pulse_strobe();
    chk("R6 output captures on second edge", a_val, 4'h5);
    out_ce_n = 1'b1;
    b_lanes = pack4(4'h9, 4'hA, 4'hD, 4'hF);
    pulse_strobe();
    chk("R7 output ce high holds", a_val, 4'h5);
    out_le = 1'b1; cyc(1);
    chk("R5 output follows node", a_val, 4'hD);
  endtask

  task automatic t_drive();
    a_oe_n = 1'b1; #1;
    chk("R9 drive off", {3'b0, a_drive}, 4'h0);
    chk("R9 value kept while undriven", a_val, 4'hD);
    a_oe_n = 1'b0; #1;
    chk("R9 drive on", {3'b0, a_drive}, 4'h1);
  endtask

  task automatic t_reset_clear();
    rst = 1'b1; cyc(1);
    chk("R10 output cleared", a_val, 4'h0);
    rst = 1'b0; lane_le = '0; out_le = 1'b1; lane_sel = 2'd3; cyc(2);
    chk("R10 lane4 cleared", a_val, 4'h0);
  endtask

  initial begin
    t_reset_state();
    t_transparent();
    t_lane_capture();
    t_held_strobe();
    t_ce_blocked();
    t_pipeline();
    t_drive();
    t_reset_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog expired got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule